// File: doc/BRIEF.md
# Interrupt Gate Fetch and Validation Sequencer

This controller opens the delivery of a 64-bit-mode interrupt. After a `start` pulse it captures an 8-bit vector and three table bases: the interrupt table, the global descriptor table and the local descriptor table. It then reads the 16-byte gate for that vector as two 64-bit words through a memory port. It tests the gate type and pulls out the code-segment selector. The selector's table bit chooses which descriptor table the target descriptor is read from. The 64-bit target offset is assembled from the split offset fields of the gate and must be canonical.

The block ends each sequence with one of two one-cycle pulses. `done` presents the target offset, selector, descriptor, stack-table index and gate type. `fault` is a general-protection fault whose error code is zero. After a fault no further memory request is issued. Permission checks beyond the type test, paging and limit checks belong to later stages.

The memory port has two valid/ready channels. On the request channel the block holds `mreq_valid` and `mreq_addr` unchanged until the cycle in which `mreq_ready` is high. On the response channel the block raises `mrsp_ready` only while it waits for a response, and a word is taken in the cycle when `mrsp_valid` and `mrsp_ready` are both high. Only one request is in flight at a time.

Top module: `intgate_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `done`, `fault`, `mreq_valid` and `mrsp_ready` are low.
- R2: The first request goes to `idt_base + vector*16` and returns the low gate word. The second request goes to that address plus 8 and returns the high gate word. No request is issued while a response is awaited.
- R3: A request whose `mreq_ready` is low stays valid with an unchanged address in the next cycle.
- R4: The gate type is low-word bits 43:40. The gate is accepted only when `type & 4'hE == 4'hE`. Otherwise `fault` pulses with `fault_code` 0 and the high word is never requested.
- R5: The selector is low-word bits 31:16. The descriptor request address is `(sel[2] ? ldt_base : gdt_base) + (sel & 16'h00F8)`.
- R6: The target offset is `{high[31:0], low[63:48], low[15:0]}`. It is accepted only if bits 63:47 are all zeros or all ones. Otherwise `fault` pulses with `fault_code` 0 and no descriptor request is made.
- R7: When `done` is high, the outputs hold the offset, the selector, the descriptor word, the stack-table index (low-word bits 34:32) and the type.
- R8: `done` and `fault` are never high together. Each is high for exactly one cycle, in the cycle after the response that completes or fails the sequence is accepted.
- R9: A `start` that arrives while a sequence is running is ignored. The running sequence keeps its own vector and bases, and the ignored start produces no extra request, `done` or `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sequence (taken only when idle) |
| vector | input | 8 | Interrupt vector |
| idt_base | input | 64 | Interrupt table base address |
| gdt_base | input | 64 | Global descriptor table base |
| ldt_base | input | 64 | Local descriptor table base |
| mreq_valid | output | 1 | Read request valid |
| mreq_ready | input | 1 | Read request accepted |
| mreq_addr | output | 64 | Read byte address |
| mrsp_valid | input | 1 | Read data valid |
| mrsp_ready | output | 1 | Block can take read data |
| mrsp_data | input | 64 | Read data word |
| done | output | 1 | Sequence completed (one cycle) |
| fault | output | 1 | General-protection fault (one cycle) |
| fault_code | output | 16 | Fault error code (always zero) |
| tgt_offset | output | 64 | Assembled target offset |
| tgt_sel | output | 16 | Target code-segment selector |
| tgt_desc | output | 64 | Target code-segment descriptor |
| tgt_ist | output | 3 | Stack-table index from the gate |
| tgt_type | output | 4 | Gate type field |

## Verification
- Every result of this block is due one cycle after a response handshake. `done` follows the accepted descriptor word, a type `fault` follows the low gate word, and a canonical `fault` follows the high gate word.
- The bench memory model records the cycle number of each response handshake and of each `done` or `fault` pulse. Each check then compares the pulse cycle with the handshake cycle plus one, so the timing is held exact under varied response latency and request stalls.
- The output values are sampled two nanoseconds after the edge in which the pulse is seen. One cycle later the bench confirms that the pulse has dropped.

// File: rtl/intgate_pkg.sv
package intgate_pkg;
  localparam int GATE_W = 64;
  localparam int SEL_W  = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ_LO, ST_WAIT_LO, ST_REQ_HI, ST_WAIT_HI,
    ST_REQ_DSC, ST_WAIT_DSC, ST_DONE, ST_FAULT
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_GATE_LO, PH_GATE_HI, PH_DESC
  } fetch_ph_e;
endpackage

// File: rtl/intgate_addr.sv
module intgate_addr
  import intgate_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VEC_W  = 8
) (
  input  fetch_ph_e          ph,
  input  logic [ADDR_W-1:0]  idt_base,
  input  logic [ADDR_W-1:0]  gdt_base,
  input  logic [ADDR_W-1:0]  ldt_base,
  input  logic [VEC_W-1:0]   vec,
  input  logic [SEL_W-1:0]   sel,
  output logic [ADDR_W-1:0]  addr
);
  localparam int GATE_SHIFT = 4;   // 16-byte gates
  localparam int HALF_OFS   = 8;   // high word follows low word
  localparam logic [SEL_W-1:0] IDX_MASK = SEL_W'(16'h00F8);

  logic [ADDR_W-1:0] gate_ofs;
  logic [ADDR_W-1:0] dsc_ofs;
  logic [ADDR_W-1:0] tbl_base;

  assign gate_ofs = ADDR_W'(vec) << GATE_SHIFT;
  assign dsc_ofs  = ADDR_W'(sel & IDX_MASK);
  assign tbl_base = sel[2] ? ldt_base : gdt_base;

  always_comb begin
    unique case (ph)
      PH_GATE_LO: addr = idt_base + gate_ofs;
      PH_GATE_HI: addr = idt_base + gate_ofs + ADDR_W'(HALF_OFS);
      default:    addr = tbl_base + dsc_ofs;
    endcase
  end
endmodule

// File: rtl/intgate_check.sv
module intgate_check
  import intgate_pkg::*;
#(
  parameter int VA_BITS = 48
) (
  input  logic [GATE_W-1:0] lo,
  input  logic [GATE_W-1:0] hi,
  output logic              type_ok,
  output logic              canon_ok,
  output logic [3:0]        gtype,
  output logic [2:0]        ist,
  output logic [SEL_W-1:0]  sel,
  output logic [GATE_W-1:0] offset
);
  logic unused_gate_bits;
  assign unused_gate_bits = ^{hi[63:32], lo[47:44], lo[39:35]};

  assign gtype   = lo[43:40];
  assign type_ok = (gtype & 4'hE) == 4'hE;
  assign sel     = lo[31:16];
  assign ist     = lo[34:32];
  assign offset  = {hi[31:0], lo[63:48], lo[15:0]};

  generate
    if (VA_BITS >= GATE_W) begin : g_full
      assign canon_ok = 1'b1;
    end else begin : g_sext
      localparam int TOP_N = GATE_W - VA_BITS + 1;
      logic [TOP_N-1:0] top_bits;
      assign top_bits = offset[GATE_W-1:VA_BITS-1];
      assign canon_ok = (top_bits == '0) || (top_bits == '1);
    end
  endgenerate
endmodule

// File: rtl/intgate_seq.sv
module intgate_seq
  import intgate_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VEC_W   = 8,
  parameter int VA_BITS = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VEC_W-1:0]  vector,
  input  logic [ADDR_W-1:0] idt_base,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] ldt_base,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_addr,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic [63:0]       mrsp_data,
  output logic              done,
  output logic              fault,
  output logic [15:0]       fault_code,
  output logic [63:0]       tgt_offset,
  output logic [15:0]       tgt_sel,
  output logic [63:0]       tgt_desc,
  output logic [2:0]        tgt_ist,
  output logic [3:0]        tgt_type
);
  seq_state_e        state, state_n;
  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] idt_q, gdt_q, ldt_q;
  logic [GATE_W-1:0] lo_q, hi_q, desc_q;
  logic [GATE_W-1:0] lo_in, hi_in;
  logic              type_ok, canon_ok, rsp_take;
  fetch_ph_e         ph;

  assign rsp_take = mrsp_valid && mrsp_ready;
  // Checks run on the arriving word so a failing field faults without a spare state
  assign lo_in = (state == ST_WAIT_LO) ? mrsp_data : lo_q;
  assign hi_in = (state == ST_WAIT_HI) ? mrsp_data : hi_q;

  intgate_check #(.VA_BITS(VA_BITS)) u_check (
    .lo(lo_in), .hi(hi_in), .type_ok(type_ok), .canon_ok(canon_ok),
    .gtype(tgt_type), .ist(tgt_ist), .sel(tgt_sel), .offset(tgt_offset)
  );

  always_comb begin
    unique case (state)
      ST_REQ_LO: ph = PH_GATE_LO;
      ST_REQ_HI: ph = PH_GATE_HI;
      default:   ph = PH_DESC;
    endcase
  end

  intgate_addr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_addr (
    .ph(ph), .idt_base(idt_q), .gdt_base(gdt_q), .ldt_base(ldt_q),
    .vec(vec_q), .sel(tgt_sel), .addr(mreq_addr)
  );

  assign mreq_valid = (state == ST_REQ_LO) || (state == ST_REQ_HI) || (state == ST_REQ_DSC);
  assign mrsp_ready = (state == ST_WAIT_LO) || (state == ST_WAIT_HI) || (state == ST_WAIT_DSC);
  assign done       = (state == ST_DONE);
  assign fault      = (state == ST_FAULT);
  assign fault_code = '0;
  assign tgt_desc   = desc_q;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:     if (start) state_n = ST_REQ_LO;
      ST_REQ_LO:   if (mreq_ready) state_n = ST_WAIT_LO;
      ST_WAIT_LO:  if (rsp_take) state_n = type_ok ? ST_REQ_HI : ST_FAULT;
      ST_REQ_HI:   if (mreq_ready) state_n = ST_WAIT_HI;
      ST_WAIT_HI:  if (rsp_take) state_n = canon_ok ? ST_REQ_DSC : ST_FAULT;
      ST_REQ_DSC:  if (mreq_ready) state_n = ST_WAIT_DSC;
      ST_WAIT_DSC: if (rsp_take) state_n = ST_DONE;
      default:     state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      vec_q  <= '0;
      idt_q  <= '0;
      gdt_q  <= '0;
      ldt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      desc_q <= '0;
    end else begin
      state <= state_n;
      if (state == ST_IDLE && start) begin
        vec_q <= vector;
        idt_q <= idt_base;
        gdt_q <= gdt_base;
        ldt_q <= ldt_base;
      end
      if (rsp_take && state == ST_WAIT_LO)  lo_q   <= mrsp_data;
      if (rsp_take && state == ST_WAIT_HI)  hi_q   <= mrsp_data;
      if (rsp_take && state == ST_WAIT_DSC) desc_q <= mrsp_data;
    end
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_fault_single: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault);
  a_r8_done_after_desc: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_DSC && rsp_take) |=> done);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));
  a_r4_quiet_after_fault: assert property (@(posedge clk) disable iff (rst)
    fault |=> !mreq_valid);
  a_r6_done_canonical: assert property (@(posedge clk) disable iff (rst)
    done |-> (tgt_offset[63:VA_BITS-1] == '0 || tgt_offset[63:VA_BITS-1] == '1));
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> $stable(vec_q));
  a_r2_no_req_while_waiting: assert property (@(posedge clk) disable iff (rst)
    (mrsp_ready && !mrsp_valid) |=> !mreq_valid);
endmodule

// File: tb/intgate_seq_bench.sv
module intgate_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0]  vector = '0;
  logic [63:0] idt_base = 64'h0000_0000_0010_0000;
  logic [63:0] gdt_base = 64'h0000_0000_0020_0000;
  logic [63:0] ldt_base = 64'h0000_0000_0030_0000;
  logic        mreq_valid, mrsp_ready, done, fault;
  logic        mreq_ready = 1'b0;
  logic        mrsp_valid = 1'b0;
  logic [63:0] mreq_addr, mrsp_data = '0;
  logic [15:0] fault_code, tgt_sel;
  logic [63:0] tgt_offset, tgt_desc;
  logic [2:0]  tgt_ist;
  logic [3:0]  tgt_type;

  always #4 clk = ~clk;

  intgate_seq u_intgate_seq (
    .clk(clk), .rst(rst), .start(start), .vector(vector),
    .idt_base(idt_base), .gdt_base(gdt_base), .ldt_base(ldt_base),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data),
    .done(done), .fault(fault), .fault_code(fault_code),
    .tgt_offset(tgt_offset), .tgt_sel(tgt_sel), .tgt_desc(tgt_desc),
    .tgt_ist(tgt_ist), .tgt_type(tgt_type)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0, nreq = 0, ndone = 0, nfault = 0;
  int last_rsp_cyc = 0, end_cyc = 0, lat = 0, pend_cnt = 0;
  bit stall = 0, pend = 0;
  logic [63:0] pend_addr = '0;
  logic [63:0] reqlog [0:63];
  logic [63:0] mem [logic [63:0]];

  // memory model: registered, so all bench-side changes land at clock edges
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mreq_ready <= 1'b0;
      mrsp_valid <= 1'b0;
      pend <= 0;
    end else begin
      mreq_ready <= stall ? ~mreq_ready : 1'b1;
      if (mreq_valid && mreq_ready) begin
        reqlog[nreq % 64] <= mreq_addr;
        nreq <= nreq + 1;
        pend <= 1;
        pend_addr <= mreq_addr;
        pend_cnt <= lat;
      end else if (pend && !mrsp_valid) begin
        if (pend_cnt == 0) begin
          mrsp_valid <= 1'b1;
          mrsp_data <= mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
          pend <= 0;
        end else pend_cnt <= pend_cnt - 1;
      end
      if (mrsp_valid && mrsp_ready) begin
        mrsp_valid <= 1'b0;
        last_rsp_cyc <= cyc;
      end
      if (done)  begin ndone  <= ndone + 1;  end_cyc <= cyc; end
      if (fault) begin nfault <= nfault + 1; end_cyc <= cyc; end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // pulse start, wait for done or fault, sample 2 ns after that edge
  task automatic run(input logic [7:0] v, output bit saw_done, output bit saw_fault);
    @(negedge clk); start = 1'b1; vector = v;
    @(negedge clk); start = 1'b0;
    saw_done = 0; saw_fault = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #2;
      if (done || fault) begin
        saw_done = done; saw_fault = fault;
        break;
      end
    end
  endtask

  task automatic after_pulse(input string req);
    @(posedge clk); #2;
    chk(req, "pulse one cycle, end at response+1", {62'd0, done, fault}, 64'd0);
    chk(req, "end cycle", 64'(end_cyc), 64'(last_rsp_cyc + 1));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "done/fault/req/rspready after reset",
        {60'd0, done, fault, mreq_valid, mrsp_ready}, 64'd0);
  endtask

  task automatic t_gdt_interrupt_gate;
    bit d, f; int base;
    lat = 0; stall = 0;
    mem[64'h100210] = 64'h1234_8E00_0010_5678;
    mem[64'h100218] = 64'h0000_0000_0000_0000;
    mem[64'h200010] = 64'h00AF_9B00_0000_FFFF;
    base = nreq;
    run(8'h21, d, f);
    chk("R7", "done seen", {62'd0, d, f}, 64'd2);
    chk("R7", "offset", tgt_offset, 64'h0000_0000_1234_5678);
    chk("R5", "selector", {48'd0, tgt_sel}, 64'h10);
    chk("R7", "descriptor", tgt_desc, 64'h00AF_9B00_0000_FFFF);
    chk("R7", "ist/type", {57'd0, tgt_ist, tgt_type}, {57'd0, 3'd0, 4'hE});
    chk("R2", "low gate address", reqlog[base % 64], 64'h100210);
    chk("R2", "high gate address", reqlog[(base + 1) % 64], 64'h100218);
    chk("R5", "global table address", reqlog[(base + 2) % 64], 64'h200010);
    after_pulse("R8");
    chk("R2", "request count", 64'(nreq - base), 64'd3);
  endtask

  task automatic t_ldt_trap_gate_stalled;
    bit d, f; int base;
    lat = 3; stall = 1;
    mem[64'h100FF0] = 64'h0000_8F05_002F_ABCD;
    mem[64'h100FF8] = 64'h0000_0000_FFFF_8000;
    mem[64'h300028] = 64'h0020_9A00_0000_0000;
    base = nreq;
    run(8'hFF, d, f);
    chk("R7", "done seen", {62'd0, d, f}, 64'd2);
    chk("R6", "negative canonical offset", tgt_offset, 64'hFFFF_8000_0000_ABCD);
    chk("R7", "ist/type", {57'd0, tgt_ist, tgt_type}, {57'd0, 3'd5, 4'hF});
    chk("R2", "top vector gate address", reqlog[base % 64], 64'h100FF0);
    chk("R5", "local table, masked index", reqlog[(base + 2) % 64], 64'h300028);
    chk("R3", "stalled request count", 64'(nreq - base), 64'd3);
    after_pulse("R8");
    stall = 0;
  endtask

  task automatic t_bad_type;
    bit d, f; int base;
    lat = 1;
    mem[64'h100050] = 64'h0000_8C00_0010_0000;
    base = nreq;
    run(8'h05, d, f);
    chk("R4", "fault seen", {62'd0, d, f}, 64'd1);
    chk("R4", "fault code", {48'd0, fault_code}, 64'd0);
    after_pulse("R8");
    repeat (4) @(posedge clk);
    #2;
    chk("R4", "no request after type fault", 64'(nreq - base), 64'd1);
  endtask

  task automatic t_noncanonical;
    bit d, f; int base;
    lat = 0;
    mem[64'h100060] = 64'h0000_8E00_0010_0000;
    mem[64'h100068] = 64'h0000_0000_0000_8000;
    base = nreq;
    run(8'h06, d, f);
    chk("R6", "fault seen", {62'd0, d, f}, 64'd1);
    chk("R6", "fault code", {48'd0, fault_code}, 64'd0);
    after_pulse("R8");
    repeat (4) @(posedge clk);
    #2;
    chk("R6", "no descriptor request", 64'(nreq - base), 64'd2);
  endtask

  task automatic t_canon_edge;
    bit d, f;
    lat = 2;
    mem[64'h100070] = 64'hFFFF_8E00_0018_FFFF;
    mem[64'h100078] = 64'h0000_0000_0000_7FFF;
    mem[64'h200018] = 64'h1111_2222_3333_4444;
    run(8'h07, d, f);
    chk("R6", "largest positive canonical accepted", {62'd0, d, f}, 64'd2);
    chk("R6", "offset", tgt_offset, 64'h0000_7FFF_FFFF_FFFF);
    after_pulse("R8");
  endtask

  task automatic t_busy_start;
    bit d, f; int base, dn0;
    lat = 4;
    mem[64'h100300] = 64'h0000_8E00_0008_0100;
    mem[64'h100308] = 64'h0;
    mem[64'h200008] = 64'hAAAA_BBBB_CCCC_DDDD;
    base = nreq; dn0 = ndone;
    @(negedge clk); start = 1'b1; vector = 8'h30;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; vector = 8'h40; idt_base = 64'h0000_0000_0090_0000;
    @(negedge clk); start = 1'b0;
    d = 0; f = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #2;
      if (done || fault) begin d = done; f = fault; break; end
    end
    chk("R9", "first sequence finished", {62'd0, d, f}, 64'd2);
    chk("R9", "descriptor of original vector", tgt_desc, 64'hAAAA_BBBB_CCCC_DDDD);
    chk("R9", "high gate kept original base", reqlog[(base + 1) % 64], 64'h100308);
    repeat (8) @(posedge clk);
    #2;
    chk("R9", "no extra requests", 64'(nreq - base), 64'd3);
    chk("R9", "one done only", 64'(ndone - dn0), 64'd1);
    idt_base = 64'h0000_0000_0010_0000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_gdt_interrupt_gate();
    t_ldt_trap_gate_stalled();
    t_bad_type();
    t_noncanonical();
    t_canon_edge();
    t_busy_start();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule